// File: doc/BRIEF.md
# Address-Sequence Command Detector

This block sits beside a memory port and watches the stream of chip-enable-controlled accesses. Each access arrives as a one-cycle strobe with a read/write flag and an address. Six reads in a fixed order form a command. The first five addresses are the same for both commands. The sixth address then chooses between a request to copy the working memory into persistent storage (store) and a request to copy persistent storage back into the working memory (recall).

The request leaves the block as a one-cycle pulse. The controller that runs the transfer raises a busy input while it works, and the detector ignores all accesses for as long as busy is high. A write, or a read of any address other than the next expected one, cancels the sequence in progress. If that stray read is the first address of the sequence, it starts a new attempt.

Top module: `seqcmd_detect`

## Requirements
- R1: When the reads 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F are followed by a read of 0x0FC0, store_req is high for the one cycle after the clock edge that samples that sixth strobe. A strobe is a read when acc_is_read=1.
- R2: When the same five reads are followed by a read of 0x0C63, recall_req is high for the one cycle after the clock edge that samples that sixth strobe.
- R3: A write (acc_is_read=0) at any step cancels the progress. No request follows unless the sequence is started again from its first address.
- R4: A read of an address that is not the next expected one cancels the progress, and no request follows from the rest of the old sequence.
- R5: A stray read of 0x0E38 at any step counts as the first step of a new sequence, so the next five correct reads complete a command.
- R6: After a request pulse the detector is idle. A sixth-step address sent alone, or the tail of the sequence, produces no further request.
- R7: While busy=1, strobes have no effect. They neither advance nor cancel the progress, and they issue no request.
- R8: store_req and recall_req are never high together, and each pulse lasts exactly one cycle.
- R9: A synchronous reset (rst=1, active high) returns the detector to idle and holds both request outputs low. Progress made before the reset is lost.
- R10: Clock cycles with acc_strobe=0 between the accesses leave the progress unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busy | input | 1 | Transfer in progress; strobes are ignored while high |
| acc_strobe | input | 1 | One-cycle marker of a chip-enable-controlled access |
| acc_is_read | input | 1 | 1 = read access, 0 = write access |
| acc_addr | input | ADDR_W (15) | Address of the access |
| store_req | output | 1 | One-cycle store request pulse |
| recall_req | output | 1 | One-cycle recall request pulse |

## Verification
The hardest case to reach is a stray read that is not expected at its step but equals the first address. Such a read must reset the progress to step one rather than to zero. The stimulus sends part of the prefix, then 0x0E38, then the rest of the sequence, and expects a pulse. A second hard case is a set of strobes that arrive while busy is high between prefix steps, including writes and wrong reads. The stimulus drops busy afterwards and finishes the sequence, and a pulse must still appear. This shows that the ignored accesses left the progress untouched.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;
   localparam int unsigned KEY_W      = 15;
   localparam int unsigned PREFIX_LEN = 5;

   typedef logic [KEY_W-1:0] key_t;

   localparam key_t STORE_KEY  = 15'h0FC0;
   localparam key_t RECALL_KEY = 15'h0C63;

   function automatic key_t prefix_at(input int unsigned idx);
      key_t k;
      case (idx)
         0: k = 15'h0E38;
         1: k = 15'h31C7;
         2: k = 15'h03E0;
         3: k = 15'h3C1F;
         default: k = 15'h303F;
      endcase
      return k;
   endfunction
endpackage

// File: rtl/seqcmd_match.sv
module seqcmd_match
   import seqcmd_pkg::*;
#(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned STEP_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [STEP_W-1:0] step,
   output logic              hit_step,
   output logic              hit_first,
   output logic              hit_store,
   output logic              hit_recall
);
   logic [PREFIX_LEN-1:0] pfx_hit;

   for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_cmp
      assign pfx_hit[g] = (addr == ADDR_W'(prefix_at(g)));
   end

   always_comb begin
      hit_step = 1'b0;
      for (int i = 0; i < PREFIX_LEN; i++) begin
         if (step == STEP_W'(i)) hit_step = pfx_hit[i];
      end
   end

   assign hit_first  = pfx_hit[0];
   assign hit_store  = (addr == ADDR_W'(STORE_KEY));
   assign hit_recall = (addr == ADDR_W'(RECALL_KEY));

   // R8 support: the two command keys differ, so they can never both match
   always_comb begin
      a_keys_excl_r8: assert (!(hit_store && hit_recall));
   end
endmodule

// File: rtl/seqcmd_track.sv
module seqcmd_track
   import seqcmd_pkg::*;
#(
   parameter int unsigned STEP_W  = 3,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              busy,
   input  logic              strobe,
   input  logic              is_read,
   input  logic              hit_step,
   input  logic              hit_first,
   input  logic              hit_store,
   input  logic              hit_recall,
   output logic [STEP_W-1:0] step,
   output logic              store_req,
   output logic              recall_req
);
   localparam logic [STEP_W-1:0] LAST = STEP_W'(PREFIX_LEN);

   logic              take;
   logic              at_last;
   logic [STEP_W-1:0] step_nx;
   logic              fire_s;
   logic              fire_r;

   assign take    = strobe & ~busy;
   assign at_last = (step == LAST);

   always_comb begin
      step_nx = step;
      fire_s  = 1'b0;
      fire_r  = 1'b0;
      if (take) begin
         if (!is_read) begin
            step_nx = '0;
         end else if (at_last && hit_store) begin
            fire_s  = 1'b1;
            step_nx = '0;
         end else if (at_last && hit_recall) begin
            fire_r  = 1'b1;
            step_nx = '0;
         end else if (!at_last && hit_step) begin
            step_nx = step + 1'b1;
         end else if (hit_first) begin
            step_nx = STEP_W'(1);
         end else begin
            step_nx = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) step <= '0;
      else     step <= step_nx;
   end

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (rst) begin
            store_req  <= 1'b0;
            recall_req <= 1'b0;
         end else begin
            store_req  <= fire_s;
            recall_req <= fire_r;
         end
      end

      // R6: a pulse appears only as the detector drops from the last step to idle
      p_cmd_idle_r6: assert property (@(posedge clk) disable iff (rst)
         (store_req || recall_req) |-> (step == '0 && $past(step) == LAST));
   end else begin : g_comb_out
      assign store_req  = fire_s & ~rst;
      assign recall_req = fire_r & ~rst;
   end

   p_excl_r8: assert property (@(posedge clk) disable iff (rst)
      !(store_req && recall_req));
   p_one_store_r8: assert property (@(posedge clk) disable iff (rst)
      store_req |=> !store_req);
   p_one_recall_r8: assert property (@(posedge clk) disable iff (rst)
      recall_req |=> !recall_req);
   p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
      busy |=> $stable(step));
   p_gap_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> $stable(step));
   p_write_abort_r3: assert property (@(posedge clk) disable iff (rst)
      (strobe && !busy && !is_read) |=> (step == '0));
   p_range_r4: assert property (@(posedge clk) disable iff (rst)
      step <= LAST);
   p_reset_idle_r9: assert property (@(posedge clk)
      rst |=> (step == '0 && !store_req && !recall_req));
endmodule

// File: rtl/seqcmd_detect.sv
module seqcmd_detect
   import seqcmd_pkg::*;
#(
   parameter int unsigned ADDR_W  = 15,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              busy,
   input  logic              acc_strobe,
   input  logic              acc_is_read,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              store_req,
   output logic              recall_req
);
   localparam int unsigned STEP_W = $clog2(PREFIX_LEN + 1);

   if (ADDR_W < 14) begin : g_bad_width
      $error("seqcmd_detect: ADDR_W must be at least 14 to hold every key");
   end

   logic [STEP_W-1:0] step;
   logic hit_step, hit_first, hit_store, hit_recall;

   seqcmd_match #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_match (
      .addr       (acc_addr),
      .step       (step),
      .hit_step   (hit_step),
      .hit_first  (hit_first),
      .hit_store  (hit_store),
      .hit_recall (hit_recall)
   );

   seqcmd_track #(.STEP_W(STEP_W), .REG_OUT(REG_OUT)) u_track (
      .clk        (clk),
      .rst        (rst),
      .busy       (busy),
      .strobe     (acc_strobe),
      .is_read    (acc_is_read),
      .hit_step   (hit_step),
      .hit_first  (hit_first),
      .hit_store  (hit_store),
      .hit_recall (hit_recall),
      .step       (step),
      .store_req  (store_req),
      .recall_req (recall_req)
   );
endmodule

// File: tb/sim_seqcmd_detect.sv
`timescale 1ns/1ps
module sim_seqcmd_detect;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic busy = 1'b0;
   logic acc_strobe = 1'b0;
   logic acc_is_read = 1'b1;
   logic [14:0] acc_addr = '0;
   logic store_req, recall_req;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;
   logic got_s, got_r;

   localparam logic [14:0] K_STORE  = 15'h0FC0;
   localparam logic [14:0] K_RECALL = 15'h0C63;

   always #2 clk = ~clk;

   seqcmd_detect u0 (
      .clk(clk), .rst(rst), .busy(busy), .acc_strobe(acc_strobe),
      .acc_is_read(acc_is_read), .acc_addr(acc_addr),
      .store_req(store_req), .recall_req(recall_req)
   );

   function automatic logic [14:0] pfx(input int i);
      case (i)
         0: return 15'h0E38;
         1: return 15'h31C7;
         2: return 15'h03E0;
         3: return 15'h3C1F;
         default: return 15'h303F;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one access: strobe for one cycle, outputs read at the following negedge
   task automatic access(input logic rd, input logic [14:0] a);
      @(negedge clk);
      acc_strobe = 1'b1; acc_is_read = rd; acc_addr = a;
      @(negedge clk);
      acc_strobe = 1'b0;
      got_s = store_req; got_r = recall_req;
      check(!(got_s && got_r), "R8 both pulses", 1, 0);
   endtask

   task automatic send_prefix(input int from, input int upto);
      for (int i = from; i < upto; i++) access(1'b1, pfx(i));
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_reset();
      check(store_req == 1'b0 && recall_req == 1'b0, "R9 reset outputs", store_req, 0);
   endtask

   task automatic t_store();
      send_prefix(0, 5);
      check(got_s == 0, "R1 no early pulse", got_s, 0);
      access(1'b1, K_STORE);
      check(got_s == 1, "R1 store pulse", got_s, 1);
      check(got_r == 0, "R8 no recall with store", got_r, 0);
      @(negedge clk);
      check(store_req == 0, "R8 store one cycle", store_req, 0);
   endtask

   task automatic t_recall();
      send_prefix(0, 5);
      access(1'b1, K_RECALL);
      check(got_r == 1, "R2 recall pulse", got_r, 1);
      check(got_s == 0, "R8 no store with recall", got_s, 0);
      @(negedge clk);
      check(recall_req == 0, "R8 recall one cycle", recall_req, 0);
   endtask

   task automatic t_write_abort();
      send_prefix(0, 3);
      access(1'b0, pfx(3));
      send_prefix(3, 5);
      access(1'b1, K_STORE);
      check(got_s == 0, "R3 write aborts", got_s, 0);
      access(1'b0, pfx(0));
      send_prefix(1, 5);
      access(1'b1, K_RECALL);
      check(got_r == 0, "R3 write of first address does not start", got_r, 0);
   endtask

   task automatic t_wrong_read();
      send_prefix(0, 4);
      access(1'b1, 15'h1234);
      access(1'b1, pfx(4));
      access(1'b1, K_STORE);
      check(got_s == 0, "R4 wrong read aborts", got_s, 0);
      send_prefix(0, 5);
      access(1'b1, 15'h0FC1);
      access(1'b1, K_STORE);
      check(got_s == 0, "R4 wrong sixth read aborts", got_s, 0);
   endtask

   task automatic t_restart();
      send_prefix(0, 3);
      access(1'b1, pfx(0));
      send_prefix(1, 5);
      access(1'b1, K_RECALL);
      check(got_r == 1, "R5 restart at step one", got_r, 1);
      send_prefix(0, 5);
      access(1'b1, pfx(0));
      send_prefix(1, 5);
      access(1'b1, K_STORE);
      check(got_s == 1, "R5 restart from last step", got_s, 1);
   endtask

   task automatic t_idle_after();
      send_prefix(0, 5);
      access(1'b1, K_STORE);
      access(1'b1, K_STORE);
      check(got_s == 0, "R6 lone sixth address after command", got_s, 0);
      access(1'b1, pfx(4));
      access(1'b1, K_RECALL);
      check(got_r == 0, "R6 tail after command", got_r, 0);
   endtask

   task automatic t_busy();
      send_prefix(0, 3);
      @(negedge clk); busy = 1'b1;
      access(1'b0, 15'h0000);
      access(1'b1, 15'h7777);
      access(1'b1, pfx(0));
      @(negedge clk); busy = 1'b0;
      send_prefix(3, 5);
      access(1'b1, K_STORE);
      check(got_s == 1, "R7 busy strobes ignored", got_s, 1);
      send_prefix(0, 5);
      @(negedge clk); busy = 1'b1;
      access(1'b1, K_RECALL);
      check(got_r == 0, "R7 no pulse while busy", got_r, 0);
      @(negedge clk); busy = 1'b0;
      access(1'b1, K_RECALL);
      check(got_r == 1, "R7 progress kept over busy", got_r, 1);
   endtask

   task automatic t_gap();
      for (int i = 0; i < 5; i++) begin
         access(1'b1, pfx(i));
         repeat (i + 2) @(negedge clk);
      end
      access(1'b1, K_STORE);
      check(got_s == 1, "R10 idle gaps kept", got_s, 1);
   endtask

   task automatic t_reset_mid();
      send_prefix(0, 5);
      do_reset();
      check(store_req == 0 && recall_req == 0, "R9 outputs after reset", store_req, 0);
      access(1'b1, K_STORE);
      check(got_s == 0, "R9 reset clears progress", got_s, 0);
   endtask

   initial begin
      #400000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      got_s = 1'b0; got_r = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      t_store();
      t_recall();
      t_write_abort();
      t_wrong_read();
      t_restart();
      t_idle_after();
      t_busy();
      t_gap();
      t_reset_mid();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule